// File: doc/BRIEF.md
# PRBS-7 Link Self-Test Checker

This block sits on the receive side of a serial video link, after clock recovery and word decoding. During an at-speed self-test it compares every received 24-bit payload with a PRBS-7 sequence that it generates locally. The test lasts exactly as long as the self-test enable input is held high.

While the test runs, the pass output drops low for the high half of one clock cycle for every payload that contains any bit error. A full-cycle error strobe and a saturating count of errored payloads are also provided. When the enable falls, the block stops checking. From then on the pass output holds a steady level: high if the whole test was clean, low if any payload was errored. This level stays until the next test starts, a reset, or power-down.

While a test is active, a blanking output tells the normal pixel and control outputs to shut off.

Top module: `prbs_link_chk`

## Requirements
- R1: The reference pattern uses the polynomial x^7 + x^6 + 1. From state s, each step computes n = s[6] XOR s[5] and moves to state {s[5:0], n}. One payload is 24 consecutive values of n, with the first placed in bit 23 and the last in bit 0. After 24 steps the state equals the low 7 bits of that payload.
- R2: A test starts in a cycle where the enable is high and no test is active. The first valid payload of a test, including one in the start cycle, is only used as the seed: its bits [6:0] become the reference state and it is never reported as an error. Every later valid payload is compared against the reference built from that seed.
- R3: A compared payload that differs from the reference in any number of bits, from 1 to 24, raises the error strobe for exactly the one cycle after the edge that sampled it, and it adds exactly one to the count. A matching payload leaves the strobe low.
- R4: While a test is active, the pass output is low during the high clock phase of each cycle in which the error strobe is high. It is high in the low phase of that cycle and in every other cycle of the test.
- R5: From the edge that samples the enable low onward, the pass output is held at a steady level in both clock phases: high if no payload of the finished test was errored, low otherwise.
- R6: The held result and the count are kept until the next test starts. Synchronous reset or power-down sets the pass output high and clears the count, the strobe and the blanking output.
- R7: The blanking output is high from the edge that samples the start of a test until the edge that samples the enable low or power-down.
- R8: The count of errored payloads saturates at 2^CNT_W-1 and is cleared to zero when a new test starts.
- R9: A payload with valid low, and any payload presented while no test is running, causes no strobe, does not change the count and does not advance the reference. A valid-low cycle inside a test leaves the next correct payload matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered word clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pdn_i | input | 1 | Power-down, active high, acts as a synchronous clear |
| bist_en_i | input | 1 | Self-test enable; the test lasts while it is high |
| pay_valid_i | input | 1 | Received payload strobe |
| pay_i | input | 24 | Received payload |
| pass_o | output | 1 | Per-payload error pulses while running, held result afterwards |
| blank_o | output | 1 | Shuts off the normal data outputs during a test |
| err_stb_o | output | 1 | Full-cycle strobe for each errored payload |
| err_cnt_o | output | CNT_W | Saturating count of errored payloads |

## Verification
The bench builds the checker with CNT_W = 4, so seventeen errored payloads in one test are enough to show the count stopping at 15 and then being cleared by the next start. The payload width stays at its default of 24. This means the all-ones corruption mask and the single-bit masks at bit 23, bit 6 and bit 0 exercise the full 1-to-24 error range and the seed boundary. The bench also probes the pass output in both clock phases, so the half-period error pulse can be told apart from the held result.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int LFSR_W = 7;
    localparam int PAY_W  = 24;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [PAY_W-1:0]  payload_t;

    typedef struct packed {
        payload_t bits;
        lfsr_t    next;
    } pat_t;

    typedef struct packed {
        logic load_seed;
        logic compare;
    } ctl_t;

    // Run the x^7 + x^6 + 1 register PAY_W steps; first output bit lands in the MSB
    function automatic pat_t prbs_expand(lfsr_t s);
        pat_t r;
        lfsr_t st;
        logic nb;
        st = s;
        r.bits = '0;
        for (int i = 0; i < PAY_W; i++) begin
            nb = st[6] ^ st[5];
            st = {st[5:0], nb};
            r.bits[PAY_W-1-i] = nb;
        end
        r.next = st;
        return r;
    endfunction

endpackage

// File: rtl/prbs_ref_lfsr.sv
module prbs_ref_lfsr
    import prbs_chk_pkg::*;
(
    input  logic     clk_i,
    input  logic     clr_i,
    input  logic     load_i,
    input  logic     adv_i,
    input  lfsr_t    seed_i,
    output payload_t exp_o
);
    lfsr_t state_q;
    pat_t  pat;

    always_comb pat = prbs_expand(state_q);

    assign exp_o = pat.bits;

    always_ff @(posedge clk_i) begin
        if (clr_i)       state_q <= '0;
        else if (load_i) state_q <= seed_i;
        else if (adv_i)  state_q <= pat.next;
    end

    // R9: a step is only taken on an accepted compare; without load or advance the reference holds
    assert_ref_hold_R9: assert property (@(posedge clk_i) disable iff (clr_i)
        (!load_i && !adv_i) |=> $stable(state_q));

endmodule

// File: rtl/payload_cmp.sv
module payload_cmp
    import prbs_chk_pkg::*;
(
    input  payload_t rx_i,
    input  payload_t exp_i,
    output logic     mismatch_o
);
    payload_t diff;

    always_comb begin
        diff       = rx_i ^ exp_i;
        mismatch_o = |diff;
    end

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
    import prbs_chk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pdn_i,
    input  logic             bist_en_i,
    input  logic             valid_i,
    input  logic             mismatch_i,
    output ctl_t             ctl_o,
    output logic             run_o,
    output logic             err_o,
    output logic             fail_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             run_q, seeded_q, err_q, fail_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start, seeded_eff, clr;

    always_comb begin
        clr               = rst_i | pdn_i;
        start             = bist_en_i & ~run_q;
        seeded_eff        = seeded_q & ~start;
        ctl_o.load_seed   = bist_en_i & valid_i & ~seeded_eff;
        ctl_o.compare     = bist_en_i & valid_i & seeded_eff;
    end

    always_ff @(posedge clk_i) begin
        if (clr) begin
            run_q    <= 1'b0;
            seeded_q <= 1'b0;
            err_q    <= 1'b0;
            fail_q   <= 1'b0;
            cnt_q    <= '0;
        end else begin
            run_q    <= bist_en_i;
            seeded_q <= bist_en_i & (seeded_eff | valid_i);
            err_q    <= ctl_o.compare & mismatch_i;
            if (start) begin
                fail_q <= 1'b0;
                cnt_q  <= '0;
            end
            if (ctl_o.compare && mismatch_i) begin
                fail_q <= 1'b1;
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign run_o  = run_q;
    assign err_o  = err_q;
    assign fail_o = fail_q;
    assign cnt_o  = cnt_q;

    assert_err_in_run_R9: assert property (@(posedge clk_i) disable iff (clr)
        err_q |-> run_q);

    assert_fail_sticky_R5: assert property (@(posedge clk_i) disable iff (clr)
        err_q |-> fail_q);

    assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (clr)
        (!bist_en_i && !run_q) |=> ($stable(fail_q) && $stable(cnt_q)));

    assert_clear_on_start_R8: assert property (@(posedge clk_i) disable iff (clr)
        $rose(run_q) |-> (cnt_q == '0 && !fail_q));

    assert_cnt_sat_R8: assert property (@(posedge clk_i) disable iff (clr)
        (run_q && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || !run_q || $rose(run_q)));

    assert_one_per_payload_R3: assert property (@(posedge clk_i) disable iff (clr)
        (run_q && bist_en_i && ctl_o.compare && mismatch_i && cnt_q != CNT_MAX)
            |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_seed_no_err_R2: assert property (@(posedge clk_i) disable iff (clr)
        ctl_o.load_seed |=> !err_q);

endmodule

// File: rtl/prbs_link_chk.sv
module prbs_link_chk
    import prbs_chk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pdn_i,
    input  logic             bist_en_i,
    input  logic             pay_valid_i,
    input  logic [23:0]      pay_i,
    output logic             pass_o,
    output logic             blank_o,
    output logic             err_stb_o,
    output logic [CNT_W-1:0] err_cnt_o
);
    ctl_t     ctl;
    payload_t exp_pay;
    logic     mismatch, run, err, fail;

    prbs_ref_lfsr u_ref (
        .clk_i  (clk_i),
        .clr_i  (rst_i | pdn_i),
        .load_i (ctl.load_seed),
        .adv_i  (ctl.compare),
        .seed_i (pay_i[LFSR_W-1:0]),
        .exp_o  (exp_pay)
    );

    payload_cmp u_cmp (
        .rx_i       (pay_i),
        .exp_i      (exp_pay),
        .mismatch_o (mismatch)
    );

    bist_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .pdn_i      (pdn_i),
        .bist_en_i  (bist_en_i),
        .valid_i    (pay_valid_i),
        .mismatch_i (mismatch),
        .ctl_o      (ctl),
        .run_o      (run),
        .err_o      (err),
        .fail_o     (fail),
        .cnt_o      (err_cnt_o)
    );

    // Half-period pulse: the registered error gated by the high clock phase
    assign pass_o    = run ? ~(err & clk_i) : ~fail;
    assign blank_o   = run;
    assign err_stb_o = err;

    assert_blank_off_after_end_R7: assert property (@(posedge clk_i) disable iff (rst_i || pdn_i)
        !bist_en_i |=> !blank_o);

endmodule

// File: tb/prbs_link_chk_tb_top.sv
module prbs_link_chk_tb_top;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst, pdn, en, valid;
    logic [23:0]   pay;
    logic          pass, blank, stb;
    logic [CW-1:0] cnt;

    int n_chk = 0;
    int n_err = 0;

    prbs_link_chk #(.CNT_W(CW)) dut_i (
        .clk_i(clk), .rst_i(rst), .pdn_i(pdn), .bist_en_i(en),
        .pay_valid_i(valid), .pay_i(pay), .pass_o(pass), .blank_o(blank),
        .err_stb_o(stb), .err_cnt_o(cnt)
    );

    always #5 clk = ~clk;

    localparam logic [23:0] MASKS [8] = '{
        24'h000000, 24'h000001, 24'h000000, 24'hFFFFFF,
        24'h800000, 24'h000000, 24'h000040, 24'h000000
    };

    logic [6:0] st;
    int         e_cnt;
    logic       e_fail;

    // Independent model of the reference pattern from R1: {next_state, payload}
    function automatic logic [30:0] model(logic [6:0] s);
        logic [23:0] b;
        logic [6:0]  x;
        x = s;
        for (int k = 0; k < 24; k++) begin
            b[23-k] = x[6] ^ x[5];
            x = {x[5:0], b[23-k]};
        end
        return {x, b};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive just after the falling edge, sample 2 ns after the rising edge (clock high)
    task automatic cyc(logic e, logic v, logic [23:0] p);
        @(negedge clk); #1;
        en = e; valid = v; pay = p;
        @(posedge clk); #2;
    endtask

    task automatic sat_cnt();
        if (e_cnt < 15) e_cnt++;
    endtask

    initial begin
        #2000000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [30:0] m;
        rst = 1; pdn = 0; en = 0; valid = 0; pay = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst = 0;
        @(posedge clk); #2;
        check("R6 reset pass", pass, 1);
        check("R6 reset count", cnt, 0);
        check("R7 reset blank", blank, 0);
        check("R3 reset strobe", stb, 0);

        // Test 1: seed then the vector table
        st = 7'h5A; e_cnt = 0; e_fail = 0;
        cyc(1, 1, {17'h1ABCD, st});
        check("R7 blank on start", blank, 1);
        check("R2 seed not compared", stb, 0);
        check("R8 count after start", cnt, 0);
        for (int i = 0; i < 8; i++) begin
            m = model(st);
            cyc(1, 1, m[23:0] ^ MASKS[i]);
            st = m[30:24];
            if (MASKS[i] != 0) begin sat_cnt(); e_fail = 1; end
            check("R3 strobe per payload", stb, (MASKS[i] != 0));
            check("R4 pass high phase", pass, (MASKS[i] == 0));
            check("R8 count", cnt, e_cnt);
        end
        // Low-phase probe of an errored cycle
        m = model(st);
        cyc(1, 1, ~m[23:0]);
        st = m[30:24]; sat_cnt();
        check("R4 pulse low in high phase", pass, 0);
        @(negedge clk); #1;
        valid = 0;
        check("R4 pass high in low phase", pass, 1);
        check("R3 strobe full cycle", stb, 1);
        @(posedge clk); #2;
        check("R9 valid low no strobe", stb, 0);
        check("R9 valid low no count", cnt, e_cnt);
        // Reference did not advance during the valid-low cycle
        m = model(st);
        cyc(1, 1, m[23:0]);
        st = m[30:24];
        check("R9 gap keeps alignment", stb, 0);

        // End of test 1: held failure
        cyc(0, 1, 24'h123456);
        check("R5 held fail high phase", pass, 0);
        check("R7 blank off at end", blank, 0);
        check("R3 no strobe after end", stb, 0);
        repeat (3) cyc(0, 1, 24'hFFFFFF);
        check("R9 idle payload ignored count", cnt, e_cnt);
        check("R9 idle payload no strobe", stb, 0);
        check("R6 fail held", pass, 0);
        @(negedge clk); #1;
        check("R5 held fail low phase", pass, 0);

        // Test 2: clean run with gaps
        st = 7'h33; e_cnt = 0;
        cyc(1, 1, {17'h00000, st});
        check("R8 count cleared on start", cnt, 0);
        check("R6 new test clears result", pass, 1);
        for (int i = 0; i < 6; i++) begin
            m = model(st);
            cyc(1, 1, m[23:0]);
            st = m[30:24];
            check("R3 clean payload", stb, 0);
            cyc(1, 0, 24'hDEAD00);
            check("R9 gap in test", stb, 0);
        end
        cyc(0, 0, 24'h0);
        check("R5 held pass", pass, 1);
        @(negedge clk); #1;
        check("R5 held pass low phase", pass, 1);

        // Test 3: saturation
        st = 7'h01; e_cnt = 0;
        cyc(1, 1, {17'h1FFFF, st});
        for (int i = 0; i < 17; i++) begin
            m = model(st);
            cyc(1, 1, ~m[23:0]);
            st = m[30:24]; sat_cnt();
            check("R8 saturating count", cnt, e_cnt);
        end
        check("R8 saturated at max", cnt, 15);
        cyc(0, 0, 24'h0);
        check("R5 held fail after sat", pass, 0);

        // Power-down clears the held result
        @(negedge clk); #1 pdn = 1;
        @(posedge clk); #2;
        check("R6 pdn pass", pass, 1);
        check("R6 pdn count", cnt, 0);
        @(negedge clk); #1 pdn = 0;

        // Power-down mid-test drops blanking
        st = 7'h40;
        cyc(1, 1, {17'h0F0F0, st});
        check("R7 blank in test", blank, 1);
        @(negedge clk); #1 pdn = 1;
        @(posedge clk); #2;
        check("R7 pdn drops blank", blank, 0);
        @(negedge clk); #1 pdn = 0; en = 0;

        // Reset clears a held failure
        st = 7'h7F;
        cyc(1, 1, {17'h0, st});
        m = model(st);
        cyc(1, 1, m[23:0] ^ 24'h000080);
        check("R3 single bit error", stb, 1);
        cyc(0, 0, 24'h0);
        check("R5 fail held before reset", pass, 0);
        @(negedge clk); #1 rst = 1;
        @(posedge clk); #2;
        check("R6 reset clears held fail", pass, 1);
        check("R6 reset clears count", cnt, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule